// File: doc/BRIEF.md
# Data Address Translation Unit with Unified TLB

This block turns a 32-bit virtual data address into a physical address within one clock. It first classifies the address by its top bits. Two fixed windows skip the TLB. One takes the low 29 bits as the physical address. The top region passes through unchanged. Outside those windows, with translation switched off, the low 29 bits are used directly. With translation on, the address is looked up in a fully associative array of 64 entries. Each entry carries its own page size, address-space tag, share flag, protection pair, dirty flag and cacheable flag.

Software fills an entry through a load port that writes the slot chosen by a replacement counter. The counter moves forward once for every request that consults the array. A software-set upper bound limits its range, and it wraps to 0 past that bound. Faulting requests record the faulting address and the page number of that address. These two records are what a miss handler needs in order to refill the array. A single-cycle invalidate clears every entry.

Top module: `dxlate_top`

## Requirements
- R1: In privileged mode, addresses 0x80000000..0xBFFFFFFF translate to {3'b000, addr[28:0]} and addresses 0xE0000000..0xFFFFFFFF translate to themselves. Neither raises a fault nor consults the array.
- R2: In user mode, a request into either fixed window is an address error with code 0x0E0 for a read and 0x100 for a write. The exception is 0xE0000000..0xE3FFFFFF, which behaves as in R1.
- R3: With at_en=0, every address outside the fixed windows translates to {3'b000, addr[28:0]} with no fault, and the replacement counter does not move.
- R4: Page size code 0, 1, 2 or 3 selects a page of 1 KB, 4 KB, 64 KB or 1 MB. A hit returns the entry's page frame bits above the page offset and the virtual address bits within it. Virtual page bits below the page size are ignored when matching.
- R5: An entry matches only if its tag equals cur_asid. The tag is not compared when the entry's share flag is set, or for any entry when sv_mode=1 and req_priv=1.
- R6: When no valid entry matches, a read gives code 0x040 and a write gives code 0x060.
- R7: When two or more valid entries match, the code is 0x140.
- R8: A user-mode access to an entry whose protection bit 1 is clear is a violation: code 0x0A0 for a read and 0x0C0 for a write. A write to an entry whose protection bit 0 is clear is also a violation, with code 0x0C0.
- R9: A write that passes the protection checks on an entry with dirty flag 0 gives code 0x080.
- R10: Every fault loads tea with the request address. Every fault except 0x140 loads flt_vpn with addr[31:10]. A request without a fault changes neither.
- R11: The counter repl_idx increases by one on each request that consults the array. The next value becomes 0 when it would exceed a nonzero urb or exceed 63. Otherwise the counter holds its value.
- R12: A pulse on ld_en writes the ld_* fields into entry repl_idx. The load does not move the counter.
- R13: inv_all clears every valid flag at the next edge. A load in the same cycle is discarded.
- R14: Each request produces rsp_valid one cycle later. With it come rsp_fault, rsp_code (0 when there is no fault), rsp_pa, and rsp_cacheable. rsp_cacheable is the entry's cacheable flag on a translated success and 0 on every other outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_priv | input | 1 | Privileged mode |
| at_en | input | 1 | Translation enable |
| sv_mode | input | 1 | Single-address-space mode |
| cur_asid | input | 8 | Current address-space tag |
| urb | input | 6 | Replacement counter bound, 0 means none |
| ld_en | input | 1 | Load entry at repl_idx |
| ld_vpn | input | 22 | Virtual page number |
| ld_asid | input | 8 | Entry tag |
| ld_ppn | input | 19 | Physical page number |
| ld_v | input | 1 | Valid flag |
| ld_sz | input | 2 | Page size code |
| ld_pr | input | 2 | Protection: bit 1 user access, bit 0 write |
| ld_c | input | 1 | Cacheable flag |
| ld_d | input | 1 | Dirty flag |
| ld_sh | input | 1 | Share flag |
| inv_all | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Fault flag |
| rsp_code | output | 12 | Fault code |
| rsp_cacheable | output | 1 | Cacheable result |
| tea | output | 32 | Last faulting address |
| flt_vpn | output | 22 | Page number captured on fault |
| repl_idx | output | 6 | Replacement counter |

## Verification
The assertions are checked on every cycle and cover the control-flow properties. They check that a response follows only a request and that the page offset survives every successful path. They check the fault records: the address is always captured, and the page number is held on a multi-hit. They check that the counter either holds or steps by one or wraps, and that an invalidate leaves no valid flag. Only the bench's scenarios show the values themselves: the actual physical addresses and fault codes, the tag and share matching, and the four page sizes. The scenarios also show the exact wrap point under a bound, and that a load in the same cycle as an invalidate is discarded.

// File: rtl/dx_pkg.sv
// Shared widths, entry layout and fault codes for the data address translator.
// Assumes a 32-bit virtual space, a 29-bit physical space and 1 KB minimum pages.
package dx_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int PG_SH  = 10;
    localparam int VPN_W  = VA_W - PG_SH;
    localparam int PPN_W  = PA_W - PG_SH;
    localparam int ASID_W = 8;

    // Stored payload of one entry; the valid flag is kept apart so it can be reset.
    typedef struct packed {
        logic              sh;
        logic              c;
        logic              d;
        logic [1:0]        pr;
        logic [1:0]        sz;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;

    typedef enum logic [11:0] {
        FC_NONE     = 12'h000,
        FC_RD_MISS  = 12'h040,
        FC_WR_MISS  = 12'h060,
        FC_FIRST_WR = 12'h080,
        FC_RD_PROT  = 12'h0A0,
        FC_WR_PROT  = 12'h0C0,
        FC_RD_ADDR  = 12'h0E0,
        FC_WR_ADDR  = 12'h100,
        FC_MULTI    = 12'h140
    } fcode_e;

    // Mask of page-offset bits for a page size code (1K, 4K, 64K, 1M).
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        int sh;
        case (sz)
            2'd0:    sh = 10;
            2'd1:    sh = 12;
            2'd2:    sh = 16;
            default: sh = 20;
        endcase
        return (VA_W'(1) << sh) - VA_W'(1);
    endfunction
endpackage

// File: rtl/dx_area.sv
// Area classifier: decides from the top six address bits whether an address
// skips translation, how it maps, and whether a user-mode access is illegal.
// Assumes the caller passes addr[31:26].
module dx_area (
    input  logic [5:0] va_top,
    input  logic       priv,
    output logic       is_fixed,
    output logic       low29,
    output logic       user_err
);
    localparam logic [1:0] LOW_WIN = 2'b10;      // 0x80000000..0xBFFFFFFF
    localparam logic [2:0] TOP_WIN = 3'b111;     // 0xE0000000 and above
    localparam logic [5:0] USR_WIN = 6'b111000;  // 0xE0000000..0xE3FFFFFF

    logic in_low, in_top;

    // Window decode and user-mode legality.
    always_comb begin
        in_low   = (va_top[5:4] == LOW_WIN);
        in_top   = (va_top[5:3] == TOP_WIN);
        is_fixed = in_low || in_top;
        low29    = in_low;
        user_err = is_fixed && !priv && (va_top != USR_WIN);
    end
endmodule

// File: rtl/dx_repl.sv
// Replacement counter: steps once per array lookup, wraps past a nonzero
// bound or past the last entry. Assumes N_ENT is a power of two.
module dx_repl #(
    parameter  int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [IDX_W-1:0] urb,
    output logic [IDX_W-1:0] rc
);
    logic [IDX_W:0]   inc;
    logic             wrap;
    logic [IDX_W-1:0] rc_q;

    // Next-value and wrap decision.
    always_comb begin
        inc  = {1'b0, rc_q} + (IDX_W+1)'(1);
        wrap = ((urb != '0) && (inc > {1'b0, urb})) || (inc > (IDX_W+1)'(N_ENT - 1));
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)   rc_q <= '0;
        else if (adv) rc_q <= wrap ? '0 : inc[IDX_W-1:0];
    end

    assign rc = rc_q;

    AST_RC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rc_q));                                      // R11
    AST_RC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (rc_q == '0) || (rc_q == $past(rc_q) + IDX_W'(1)));    // R11
endmodule

// File: rtl/dx_tlb.sv
// Fully associative entry array: per-entry match with size-dependent compare
// and tag/share qualification, load by index, one-cycle invalidate.
// Assumes the hit fields are meaningful only when exactly one entry matches.
module dx_tlb
    import dx_pkg::*;
#(
    parameter  int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic              ld_v,
    input  tlb_ent_t          ld_ent,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_use_asid,
    output logic              any_hit,
    output logic              multi_hit,
    output logic [PPN_W-1:0]  h_ppn,
    output logic [1:0]        h_sz,
    output logic [1:0]        h_pr,
    output logic              h_d,
    output logic              h_c
);
    logic [N_ENT-1:0] v_q;
    tlb_ent_t         ent_q [N_ENT];
    logic [N_ENT-1:0] hit;

    // Valid flags: cleared by reset or invalidate, set or cleared by a load.
    always_ff @(posedge clk) begin
        if (!rst_n)       v_q <= '0;
        else if (inv_all) v_q <= '0;
        else if (ld_en)   v_q[ld_idx] <= ld_v;
    end

    // Entry payload store; a load during an invalidate is discarded.
    always_ff @(posedge clk) begin
        if (ld_en && !inv_all) ent_q[ld_idx] <= ld_ent;
    end

    // Per-entry comparators.
    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
            logic tag_ok, page_ok;
            always_comb begin
                tag_ok  = ent_q[i].sh || !lk_use_asid || (ent_q[i].asid == lk_asid);
                page_ok = ((lk_va ^ {ent_q[i].vpn, {PG_SH{1'b0}}}) & ~page_mask(ent_q[i].sz)) == '0;
                hit[i]  = v_q[i] && tag_ok && page_ok;
            end
        end
    endgenerate

    // Hit summary and field selection by OR over matching entries.
    always_comb begin
        any_hit   = |hit;
        multi_hit = any_hit && (|(hit & (hit - N_ENT'(1))));
        h_ppn = '0; h_sz = '0; h_pr = '0; h_d = 1'b0; h_c = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i]) begin
                h_ppn = h_ppn | ent_q[i].ppn;
                h_sz  = h_sz  | ent_q[i].sz;
                h_pr  = h_pr  | ent_q[i].pr;
                h_d   = h_d   | ent_q[i].d;
                h_c   = h_c   | ent_q[i].c;
            end
        end
    end

    AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (v_q == '0));                                      // R13
endmodule

// File: rtl/dxlate_top.sv
// Data address translator top: area rules, translation bypass, array lookup,
// rights check, fault capture and registered response one cycle after a request.
// Assumes at most one request per cycle and a caller that holds inputs stable for it.
module dxlate_top
    import dx_pkg::*;
#(
    parameter  int N_ENT = 64,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              at_en,
    input  logic              sv_mode,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [IDX_W-1:0]  urb,
    input  logic              ld_en,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [PPN_W-1:0]  ld_ppn,
    input  logic              ld_v,
    input  logic [1:0]        ld_sz,
    input  logic [1:0]        ld_pr,
    input  logic              ld_c,
    input  logic              ld_d,
    input  logic              ld_sh,
    input  logic              inv_all,
    output logic              rsp_valid,
    output logic [VA_W-1:0]   rsp_pa,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic              rsp_cacheable,
    output logic [VA_W-1:0]   tea,
    output logic [VPN_W-1:0]  flt_vpn,
    output logic [IDX_W-1:0]  repl_idx
);
    localparam int HI_W = VA_W - PA_W;

    logic             is_fixed, low29, user_err;
    logic             use_asid, tlb_go;
    logic             any_hit, multi_hit, h_d, h_c;
    logic [PPN_W-1:0] h_ppn;
    logic [1:0]       h_sz, h_pr;
    logic [VA_W-1:0]  off_mask, tlb_pa, pa_n;
    fcode_e           code_n;
    logic             c_n;
    tlb_ent_t         ld_ent;

    logic             rsp_valid_q, fault_q, cache_q;
    logic [VA_W-1:0]  pa_q, tea_q;
    logic [11:0]      code_q;
    logic [VPN_W-1:0] vpn_q;

    dx_area u_area (
        .va_top   (req_addr[VA_W-1:VA_W-6]),
        .priv     (req_priv),
        .is_fixed (is_fixed),
        .low29    (low29),
        .user_err (user_err)
    );

    // Lookup qualification and load payload assembly.
    always_comb begin
        use_asid = !(sv_mode && req_priv);
        tlb_go   = req_valid && !is_fixed && at_en;
        ld_ent   = '{sh: ld_sh, c: ld_c, d: ld_d, pr: ld_pr, sz: ld_sz,
                     asid: ld_asid, vpn: ld_vpn, ppn: ld_ppn};
    end

    dx_repl #(.N_ENT(N_ENT)) u_repl (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tlb_go),
        .urb   (urb),
        .rc    (repl_idx)
    );

    dx_tlb #(.N_ENT(N_ENT)) u_tlb (
        .clk         (clk),
        .rst_n       (rst_n),
        .inv_all     (inv_all),
        .ld_en       (ld_en),
        .ld_idx      (repl_idx),
        .ld_v        (ld_v),
        .ld_ent      (ld_ent),
        .lk_va       (req_addr),
        .lk_asid     (cur_asid),
        .lk_use_asid (use_asid),
        .any_hit     (any_hit),
        .multi_hit   (multi_hit),
        .h_ppn       (h_ppn),
        .h_sz        (h_sz),
        .h_pr        (h_pr),
        .h_d         (h_d),
        .h_c         (h_c)
    );

    // Physical address of a translated hit: frame above the offset, VA within it.
    always_comb begin
        off_mask = page_mask(h_sz);
        tlb_pa   = ({{HI_W{1'b0}}, h_ppn, {PG_SH{1'b0}}} & ~off_mask) | (req_addr & off_mask);
    end

    // Outcome priority: area error, bypass, miss, multi-hit, rights, dirty.
    always_comb begin
        code_n = FC_NONE;
        pa_n   = '0;
        c_n    = 1'b0;
        if (is_fixed) begin
            if (user_err) code_n = req_write ? FC_WR_ADDR : FC_RD_ADDR;
            else          pa_n   = low29 ? {{HI_W{1'b0}}, req_addr[PA_W-1:0]} : req_addr;
        end else if (!at_en) begin
            pa_n = {{HI_W{1'b0}}, req_addr[PA_W-1:0]};
        end else if (!any_hit) begin
            code_n = req_write ? FC_WR_MISS : FC_RD_MISS;
        end else if (multi_hit) begin
            code_n = FC_MULTI;
        end else if (!req_priv && !h_pr[1]) begin
            code_n = req_write ? FC_WR_PROT : FC_RD_PROT;
        end else if (req_write && !h_pr[0]) begin
            code_n = FC_WR_PROT;
        end else if (req_write && !h_d) begin
            code_n = FC_FIRST_WR;
        end else begin
            pa_n = tlb_pa;
            c_n  = h_c;
        end
    end

    // Response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            fault_q     <= 1'b0;
            code_q      <= '0;
            pa_q        <= '0;
            cache_q     <= 1'b0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                fault_q <= (code_n != FC_NONE);
                code_q  <= code_n;
                pa_q    <= pa_n;
                cache_q <= c_n;
            end
        end
    end

    // Fault capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tea_q <= '0;
            vpn_q <= '0;
        end else if (req_valid && (code_n != FC_NONE)) begin
            tea_q <= req_addr;
            if (code_n != FC_MULTI) vpn_q <= req_addr[VA_W-1:PG_SH];
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_pa        = pa_q;
    assign rsp_fault     = fault_q;
    assign rsp_code      = code_q;
    assign rsp_cacheable = cache_q;
    assign tea           = tea_q;
    assign flt_vpn       = vpn_q;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));                                         // R14
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_pa[PG_SH-1:0] == $past(req_addr[PG_SH-1:0]))); // R4
    AST_CAPTURE_TEA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (tea == $past(req_addr)));                  // R10
    AST_MULTI_KEEPS_VPN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == FC_MULTI)) |-> $stable(flt_vpn));             // R10
    AST_NO_CACHE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_cacheable);                            // R14
endmodule

// File: tb/dxlate_top_bench.sv
module dxlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [31:0] req_addr = '0;
    logic        at_en = 1'b0, sv_mode = 1'b0;
    logic [7:0]  cur_asid = '0;
    logic [5:0]  urb = '0;
    logic        ld_en = 1'b0, ld_v = 1'b0, ld_c = 1'b0, ld_d = 1'b0, ld_sh = 1'b0;
    logic [21:0] ld_vpn = '0;
    logic [7:0]  ld_asid = '0;
    logic [18:0] ld_ppn = '0;
    logic [1:0]  ld_sz = '0, ld_pr = '0;
    logic        inv_all = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_cacheable;
    logic [31:0] rsp_pa, tea;
    logic [11:0] rsp_code;
    logic [21:0] flt_vpn;
    logic [5:0]  repl_idx;

    int n_chk = 0, n_fail = 0;

    // Reference state built from the requirements.
    logic        m_v   [64];
    logic [21:0] m_vpn [64];
    logic [7:0]  m_asid[64];
    logic [18:0] m_ppn [64];
    logic [1:0]  m_sz  [64], m_pr[64];
    logic        m_c   [64], m_d[64], m_sh[64];
    logic [5:0]  m_rc = '0;
    logic [31:0] m_tea = '0;
    logic [21:0] m_fv = '0;

    always #5 clk = ~clk;

    dxlate_top u_dxlate_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_priv(req_priv), .at_en(at_en), .sv_mode(sv_mode),
        .cur_asid(cur_asid), .urb(urb), .ld_en(ld_en), .ld_vpn(ld_vpn), .ld_asid(ld_asid),
        .ld_ppn(ld_ppn), .ld_v(ld_v), .ld_sz(ld_sz), .ld_pr(ld_pr), .ld_c(ld_c), .ld_d(ld_d),
        .ld_sh(ld_sh), .inv_all(inv_all), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_cacheable(rsp_cacheable),
        .tea(tea), .flt_vpn(flt_vpn), .repl_idx(repl_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int off_bits(input logic [1:0] sz);
        return (sz == 2'd0) ? 10 : (sz == 2'd1) ? 12 : (sz == 2'd2) ? 16 : 20;
    endfunction

    function automatic bit m_match(input int i, input logic [31:0] a, input logic p);
        int sh;
        sh = off_bits(m_sz[i]);
        return m_v[i] && (m_sh[i] || (sv_mode && p) || (m_asid[i] == cur_asid))
               && ((a >> sh) == ({m_vpn[i], 10'b0} >> sh));
    endfunction

    function automatic logic [5:0] rc_next(input logic [5:0] rc);
        int n;
        n = int'(rc) + 1;
        if ((urb != 0 && n > int'(urb)) || n > 63) n = 0;
        return 6'(n);
    endfunction

    task automatic t_req(input string tag, input logic [31:0] a, input logic w, input logic p);
        logic [11:0] e_code;
        logic [31:0] e_pa, msk;
        logic        e_c, go;
        int          nh, hi;
        e_code = 12'h000; e_pa = '0; e_c = 1'b0; go = 1'b0; nh = 0; hi = 0;
        if ((a >= 32'h8000_0000 && a < 32'hC000_0000) || a >= 32'hE000_0000) begin
            if (!p && !(a >= 32'hE000_0000 && a < 32'hE400_0000)) e_code = w ? 12'h100 : 12'h0E0;
            else e_pa = (a < 32'hC000_0000) ? {3'b000, a[28:0]} : a;
        end else if (!at_en) begin
            e_pa = {3'b000, a[28:0]};
        end else begin
            go = 1'b1;
            for (int i = 0; i < 64; i++) if (m_match(i, a, p)) begin nh++; hi = i; end
            if (nh == 0) e_code = w ? 12'h060 : 12'h040;
            else if (nh > 1) e_code = 12'h140;
            else if (!p && !m_pr[hi][1]) e_code = w ? 12'h0C0 : 12'h0A0;
            else if (w && !m_pr[hi][0]) e_code = 12'h0C0;
            else if (w && !m_d[hi]) e_code = 12'h080;
            else begin
                msk  = (32'd1 << off_bits(m_sz[hi])) - 32'd1;
                e_pa = ({3'b000, m_ppn[hi], 10'b0} & ~msk) | (a & msk);
                e_c  = m_c[hi];
            end
        end
        if (e_code != 12'h000) begin
            m_tea = a;
            if (e_code != 12'h140) m_fv = a[31:10];
        end
        if (go) m_rc = rc_next(m_rc);
        @(negedge clk);
        req_addr = a; req_write = w; req_priv = p; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R14 valid", 32'(rsp_valid), 32'd1);
        chk({tag, " code"}, 32'(rsp_code), 32'(e_code));
        chk("R14 fault flag", 32'(rsp_fault), 32'(e_code != 12'h000));
        if (e_code == 12'h000) chk({tag, " pa"}, rsp_pa, e_pa);
        chk("R14 cacheable", 32'(rsp_cacheable), 32'(e_c));
        chk("R10 tea", tea, m_tea);
        chk("R10 flt_vpn", 32'(flt_vpn), 32'(m_fv));
        chk("R11 repl_idx", 32'(repl_idx), 32'(m_rc));
    endtask

    task automatic t_load(input logic [31:0] va, input logic [7:0] as, input logic [18:0] pp,
                          input logic v, input logic [1:0] sz, input logic [1:0] pr,
                          input logic c, input logic d, input logic sh, input logic with_inv);
        if (!with_inv) begin
            m_v[m_rc] = v; m_vpn[m_rc] = va[31:10]; m_asid[m_rc] = as; m_ppn[m_rc] = pp;
            m_sz[m_rc] = sz; m_pr[m_rc] = pr; m_c[m_rc] = c; m_d[m_rc] = d; m_sh[m_rc] = sh;
        end else begin
            for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        end
        @(negedge clk);
        ld_vpn = va[31:10]; ld_asid = as; ld_ppn = pp; ld_v = v; ld_sz = sz; ld_pr = pr;
        ld_c = c; ld_d = d; ld_sh = sh; ld_en = 1'b1; inv_all = with_inv;
        @(negedge clk);
        ld_en = 1'b0; inv_all = 1'b0;
        chk("R12 load keeps counter", 32'(repl_idx), 32'(m_rc));
    endtask

    task automatic t_inv();
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R14 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] sz_bytes, base;
        logic [31:0] areas [8];
        for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        chk("R14 reset valid", 32'(rsp_valid), 32'd0);
        chk("R11 reset counter", 32'(repl_idx), 32'd0);
        chk("R10 reset tea", tea, 32'd0);
        chk("R10 reset vpn", 32'(flt_vpn), 32'd0);

        cur_asid = 8'h11;
        areas = '{32'h8123_4567, 32'hA765_4321, 32'hBFFF_FFFC, 32'hE000_0004,
                  32'hE3FF_FFF0, 32'hE400_0008, 32'hFFFF_FFFC, 32'hF123_0000};
        for (int at = 0; at < 2; at++) begin
            at_en = 1'(at);
            for (int p = 0; p < 2; p++)
                for (int w = 0; w < 2; w++)
                    foreach (areas[k]) t_req(p ? "R1" : "R2", areas[k], 1'(w), 1'(p));
        end
        at_en = 1'b0;
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++) begin
                t_req("R3", 32'h0000_1234, 1'(w), 1'(p));
                t_req("R3", 32'h7FFF_FFFF, 1'(w), 1'(p));
                t_req("R3", 32'hC123_4567, 1'(w), 1'(p));
                t_req("R3", 32'hDFFF_FC00, 1'(w), 1'(p));
            end

        at_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            base = 32'((s + 1) << 20);
            sz_bytes = 32'd1 << off_bits(2'(s));
            t_load(base, 8'h11, 19'h5A5A5 ^ 19'(s), 1'b1, 2'(s), 2'b11, 1'(s), 1'b1, 1'b0, 1'b0);
            for (int p = 0; p < 2; p++)
                for (int w = 0; w < 2; w++) begin
                    t_req("R4", base, 1'(w), 1'(p));
                    t_req("R4", base + sz_bytes - 32'd4, 1'(w), 1'(p));
                    t_req("R6", base + sz_bytes, 1'(w), 1'(p));
                end
        end
        t_inv();
        t_req("R13", 32'h0010_0000, 1'b0, 1'b1);

        for (int pr = 0; pr < 4; pr++)
            for (int d = 0; d < 2; d++) begin
                base = 32'h4000_0000 + 32'((pr * 2 + d) << 12);
                t_load(base, 8'h11, 19'(32'h1000 + pr * 2 + d), 1'b1, 2'd1, 2'(pr), 1'b1, 1'(d), 1'b0, 1'b0);
                for (int p = 0; p < 2; p++)
                    for (int w = 0; w < 2; w++)
                        t_req((w && pr[0] && !d && (p || pr[1])) ? "R9" : "R8", base + 32'h10, 1'(w), 1'(p));
            end
        t_inv();

        t_load(32'h5000_0000, 8'h22, 19'h00AAA, 1'b1, 2'd1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        t_req("R6", 32'h5800_0000, 1'b0, 1'b1);
        t_load(32'h5010_0000, 8'h22, 19'h00BBB, 1'b1, 2'd1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int svv = 0; svv < 2; svv++) begin
            sv_mode = 1'(svv);
            for (int p = 0; p < 2; p++)
                for (int as = 0; as < 2; as++) begin
                    cur_asid = as ? 8'h22 : 8'h11;
                    t_req("R5", 32'h5000_0040, 1'b0, 1'(p));
                    t_req("R5", 32'h5010_0080, 1'b1, 1'(p));
                end
        end
        sv_mode = 1'b0; cur_asid = 8'h11;

        t_req("R6", 32'h6100_0000, 1'b1, 1'b1);
        t_load(32'h6000_0000, 8'h11, 19'h00CCC, 1'b1, 2'd1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        t_req("R6", 32'h6200_0000, 1'b0, 1'b1);
        t_load(32'h6000_0000, 8'h11, 19'h00DDD, 1'b1, 2'd3, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        t_req("R7", 32'h6000_0100, 1'b0, 1'b1);
        t_req("R7", 32'h6000_0200, 1'b1, 1'b0);
        t_load(32'h6800_0000, 8'h11, 19'h00EEE, 1'b0, 2'd1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        t_req("R12", 32'h6800_0000, 1'b0, 1'b1);

        t_load(32'h7000_0000, 8'h11, 19'h00FFF, 1'b1, 2'd1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        t_req("R13", 32'h7000_0000, 1'b0, 1'b1);
        t_req("R13", 32'h6000_0100, 1'b0, 1'b1);

        urb = 6'd3;
        for (int k = 0; k < 8; k++) t_req("R11", 32'h0002_0000, 1'b0, 1'b1);
        urb = 6'd0;
        for (int k = 0; k < 70; k++) t_req("R11", 32'h0003_0000, 1'b1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule